// File: doc/BRIEF.md
# UART FIFO Status and Interrupt Controller

This block is the register-side status and interrupt logic of a serial port that has a receive FIFO and a transmit FIFO. It does not hold the FIFOs, shifters or baud logic. Those parts report to it through two occupancy counts and six single-cycle event strobes: receive overflow, framing error, parity error, receive timeout, modem-status change and transmit overflow. From these inputs it builds three things:

- a live status word that follows the counts and two programmable trigger levels;
- a sticky interrupt-status register into which the live conditions and the events are folded every cycle;
- a level interrupt request, gated by a mask.

Software reaches the block through a plain 32-bit register port: a write strobe, a 3-bit word index and write data. Read data is a combinational function of the index. Reads have no side effects, so there is no read strobe. The bus is a control path, not a data stream, so there is no valid/ready handshake and no back-pressure; a write is accepted in every cycle in which `reg_wr` is high. Register indices: 0 enable (write-only, reads 0), 1 disable (write-only, reads 0), 2 mask (read-only), 3 sticky status (write-one-to-clear), 4 receive trigger, 5 transmit trigger, 6 live status (read-only), 7 unused (reads 0).

Top module: `uart_irq_ctrl`

## Requirements
- R1: Live status (index 6) bit 0 is set when the receive count is greater than or equal to the receive trigger level. Bit 1 is set when the receive count is 0. Bit 2 is set when the receive count equals the FIFO depth (64).
- R2: Live status bit 3 is set when the transmit count is 0, and bit 4 when it equals the FIFO depth. Bit 13 is set when the transmit count is greater than or equal to the transmit trigger level. All other live bits read 0.
- R3: On every clock edge, each live status bit among bits 4..0 that is set sets the same bit of the sticky register (index 3). Live bit 13 sets sticky bit 10.
- R4: An event strobe high at a clock edge sets its sticky bit: receive overflow bit 5, framing bit 6, parity bit 7, receive timeout bit 8, modem change bit 9, transmit overflow bit 12. Sticky bit 11 and bits 31..13 always read 0.
- R5: A write to index 0 ORs the written value into the mask, keeping only the implemented bits 10..0 and 12 (0x17FF). A write to index 1 clears every mask bit written as one. The mask reads back at index 2.
- R6: A write to index 2 leaves the mask unchanged.
- R7: A write to index 3 clears every sticky bit written as one, unless that bit is set again in the same cycle.
- R8: When an event strobe or live condition and a clearing write hit the same sticky bit at the same edge, the bit ends up set.
- R9: `irq` is high exactly when the bitwise AND of mask and sticky register is nonzero.
- R10: While reset is held (`rst_n` low), mask and sticky read 0, `irq` is low and both trigger levels read 32.
- R11: The trigger levels (indices 4 and 5) are 6 bits wide. A write stores `reg_wdata[5:0]`, and a read returns the level zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` |
| rx_count | input | 7 | Receive FIFO occupancy, 0..64 |
| tx_count | input | 7 | Transmit FIFO occupancy, 0..64 |
| evt_rx_ovr | input | 1 | Receive overflow strobe |
| evt_frame_err | input | 1 | Framing error strobe |
| evt_parity_err | input | 1 | Parity error strobe |
| evt_rx_timeout | input | 1 | Receive timeout strobe |
| evt_modem_chg | input | 1 | Modem status change strobe |
| evt_tx_ovr | input | 1 | Transmit overflow strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The counts are swept through empty, exactly full and the trigger thresholds. This separates the equality tests (empty, full) from the greater-or-equal trigger tests, and shows whether a trigger move takes effect at the right edge. Random mixes of enable, disable, mask and clear writes with random event strobes show whether set and clear act on the intended bits and whether the transmit-trigger bit moves from position 13 to 10. Directed cycles in which a clear and an event hit the same bit check that the event wins. Writes to the read-only mask check that they are ignored.

// File: rtl/uirq_pkg.sv
`timescale 1ns/1ps
package uirq_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_EN     = 3'd0,
    IDX_DIS    = 3'd1,
    IDX_MASK   = 3'd2,
    IDX_STICKY = 3'd3,
    IDX_RXTRIG = 3'd4,
    IDX_TXTRIG = 3'd5,
    IDX_LIVE   = 3'd6,
    IDX_SPARE  = 3'd7
  } reg_idx_e;

  // live status bit positions
  localparam int LV_RXTRIG = 0;
  localparam int LV_RXEMPTY = 1;
  localparam int LV_RXFULL = 2;
  localparam int LV_TXEMPTY = 3;
  localparam int LV_TXFULL = 4;
  localparam int LV_TXTRIG = 13;

  // sticky bit positions that differ from live
  localparam int ST_RXOVR   = 5;
  localparam int ST_FRAME   = 6;
  localparam int ST_PARITY  = 7;
  localparam int ST_TIMEOUT = 8;
  localparam int ST_MODEM   = 9;
  localparam int ST_TXTRIG  = 10;
  localparam int ST_TXOVR   = 12;

  localparam int NUM_FOLD = 5;
  localparam logic [DATA_W-1:0] IRQ_VALID = 32'h0000_17FF;
endpackage

// File: rtl/uirq_status_gen.sv
`timescale 1ns/1ps
module uirq_status_gen
  import uirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 7,
  parameter int TRIG_W     = 6
) (
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [TRIG_W-1:0] rx_trig,
  input  logic [TRIG_W-1:0] tx_trig,
  output logic [DATA_W-1:0] live
);
  always_comb begin
    live = '0;
    live[LV_RXTRIG]  = 32'(rx_count) >= 32'(rx_trig);
    live[LV_RXEMPTY] = rx_count == '0;
    live[LV_RXFULL]  = 32'(rx_count) == FIFO_DEPTH;
    live[LV_TXEMPTY] = tx_count == '0;
    live[LV_TXFULL]  = 32'(tx_count) == FIFO_DEPTH;
    live[LV_TXTRIG]  = 32'(tx_count) >= 32'(tx_trig);
  end
endmodule

// File: rtl/uirq_sticky.sv
`timescale 1ns/1ps
module uirq_sticky
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] live,
  input  logic              evt_rx_ovr,
  input  logic              evt_frame_err,
  input  logic              evt_parity_err,
  input  logic              evt_rx_timeout,
  input  logic              evt_modem_chg,
  input  logic              evt_tx_ovr,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_bits,
  output logic [DATA_W-1:0] sticky_q
);
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;

  // fold live bits that share their position
  for (genvar gi = 0; gi < NUM_FOLD; gi++) begin : g_fold
    assign set_vec[gi] = live[gi];
  end
  assign set_vec[ST_RXOVR]   = evt_rx_ovr;
  assign set_vec[ST_FRAME]   = evt_frame_err;
  assign set_vec[ST_PARITY]  = evt_parity_err;
  assign set_vec[ST_TIMEOUT] = evt_rx_timeout;
  assign set_vec[ST_MODEM]   = evt_modem_chg;
  assign set_vec[ST_TXTRIG]  = live[LV_TXTRIG];
  assign set_vec[11]         = 1'b0;
  assign set_vec[ST_TXOVR]   = evt_tx_ovr;
  assign set_vec[DATA_W-1:13] = '0;

  assign clr_vec = clr_en ? clr_bits : '0;

  // set after clear: a fresh event survives a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= ((sticky_q & ~clr_vec) | set_vec) & IRQ_VALID;
  end
endmodule

// File: rtl/uirq_mask.sv
`timescale 1ns/1ps
module uirq_mask
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wbits,
  output logic [DATA_W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (set_en) mask_q <= mask_q | (wbits & IRQ_VALID);
    else if (clr_en) mask_q <= mask_q & ~wbits;
  end
endmodule

// File: rtl/uirq_level_reg.sv
`timescale 1ns/1ps
module uirq_level_reg #(
  parameter int TRIG_W     = 6,
  parameter int TRIG_RESET = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [TRIG_W-1:0] wval,
  output logic [TRIG_W-1:0] level_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  level_q <= TRIG_W'(TRIG_RESET);
    else if (we) level_q <= wval;
  end
endmodule

// File: rtl/uirq_reg_if.sv
`timescale 1ns/1ps
module uirq_reg_if
  import uirq_pkg::*;
#(
  parameter int TRIG_W = 6
) (
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] mask_q,
  input  logic [DATA_W-1:0] sticky_q,
  input  logic [DATA_W-1:0] live,
  input  logic [TRIG_W-1:0] rx_trig,
  input  logic [TRIG_W-1:0] tx_trig,
  output logic              mask_set,
  output logic              mask_clr,
  output logic              sticky_clr,
  output logic [1:0]        trig_we,
  output logic [DATA_W-1:0] reg_rdata
);
  reg_idx_e idx;
  assign idx = reg_idx_e'(reg_idx);

  assign mask_set   = reg_wr && (idx == IDX_EN);
  assign mask_clr   = reg_wr && (idx == IDX_DIS);
  assign sticky_clr = reg_wr && (idx == IDX_STICKY);
  assign trig_we[0] = reg_wr && (idx == IDX_RXTRIG);
  assign trig_we[1] = reg_wr && (idx == IDX_TXTRIG);

  always_comb begin
    unique case (idx)
      IDX_MASK:   reg_rdata = mask_q;
      IDX_STICKY: reg_rdata = sticky_q;
      IDX_RXTRIG: reg_rdata = 32'(rx_trig);
      IDX_TXTRIG: reg_rdata = 32'(tx_trig);
      IDX_LIVE:   reg_rdata = live;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int TRIG_W     = 6,
  parameter int TRIG_RESET = 32,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int NUM_TRIG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              evt_rx_ovr,
  input  logic              evt_frame_err,
  input  logic              evt_parity_err,
  input  logic              evt_rx_timeout,
  input  logic              evt_modem_chg,
  input  logic              evt_tx_ovr,
  output logic              irq
);
  logic [DATA_W-1:0]   live;
  logic [DATA_W-1:0]   mask_q;
  logic [DATA_W-1:0]   sticky_q;
  logic                mask_set, mask_clr, sticky_clr;
  logic [NUM_TRIG-1:0] trig_we;
  logic [TRIG_W-1:0]   trig_lvl [NUM_TRIG];

  for (genvar gi = 0; gi < NUM_TRIG; gi++) begin : g_trig
    uirq_level_reg #(.TRIG_W(TRIG_W), .TRIG_RESET(TRIG_RESET)) u_lvl (
      .clk(clk), .rst_n(rst_n), .we(trig_we[gi]),
      .wval(reg_wdata[TRIG_W-1:0]), .level_q(trig_lvl[gi])
    );
  end

  uirq_status_gen #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_status (
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_trig(trig_lvl[0]), .tx_trig(trig_lvl[1]), .live(live)
  );

  uirq_reg_if #(.TRIG_W(TRIG_W)) u_regs (
    .reg_wr(reg_wr), .reg_idx(reg_idx), .mask_q(mask_q), .sticky_q(sticky_q),
    .live(live), .rx_trig(trig_lvl[0]), .tx_trig(trig_lvl[1]),
    .mask_set(mask_set), .mask_clr(mask_clr), .sticky_clr(sticky_clr),
    .trig_we(trig_we), .reg_rdata(reg_rdata)
  );

  uirq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .set_en(mask_set), .clr_en(mask_clr),
    .wbits(reg_wdata), .mask_q(mask_q)
  );

  uirq_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .live(live),
    .evt_rx_ovr(evt_rx_ovr), .evt_frame_err(evt_frame_err),
    .evt_parity_err(evt_parity_err), .evt_rx_timeout(evt_rx_timeout),
    .evt_modem_chg(evt_modem_chg), .evt_tx_ovr(evt_tx_ovr),
    .clr_en(sticky_clr), .clr_bits(reg_wdata), .sticky_q(sticky_q)
  );

  assign irq = |(mask_q & sticky_q);
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
`timescale 1ns/1ps
module uart_irq_ctrl_chk
  import uirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [CNT_W-1:0]  rx_count,
  input logic [CNT_W-1:0]  tx_count,
  input logic              evt_rx_ovr,
  input logic              irq,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] sticky_q,
  input logic [DATA_W-1:0] live
);
  // R1
  rx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> live[LV_RXEMPTY]);
  // R2
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_count) == FIFO_DEPTH) |-> live[LV_TXFULL]);
  // R3
  full_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live[LV_RXFULL] |=> sticky_q[LV_RXFULL]);
  // R3
  txtrig_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live[LV_TXTRIG] |=> sticky_q[ST_TXTRIG]);
  // R8
  ovr_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_ovr |=> sticky_q[ST_RXOVR]);
  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IDX_STICKY && reg_wdata[ST_RXOVR] && !evt_rx_ovr)
      |=> !sticky_q[ST_RXOVR]);
  // R6
  mask_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IDX_MASK) |=> $stable(mask_q));
  // R5
  mask_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IDX_EN)
      |=> ((mask_q & $past(reg_wdata & IRQ_VALID)) == $past(reg_wdata & IRQ_VALID)));
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
  .reg_wdata(reg_wdata), .rx_count(rx_count), .tx_count(tx_count),
  .evt_rx_ovr(evt_rx_ovr), .irq(irq), .mask_q(mask_q),
  .sticky_q(sticky_q), .live(live)
);

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;
  import uirq_pkg::*;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, reg_wr;
  logic [2:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic [6:0]  rx_count, tx_count;
  logic [5:0]  ev;
  logic        irq;

  uart_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_count(rx_count), .tx_count(tx_count),
    .evt_rx_ovr(ev[0]), .evt_frame_err(ev[1]), .evt_parity_err(ev[2]),
    .evt_rx_timeout(ev[3]), .evt_modem_chg(ev[4]), .evt_tx_ovr(ev[5]),
    .irq(irq)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] m_mask, m_stk;
  logic [5:0]  m_rt, m_tt;
  int cur_rx, cur_tx;

  function automatic logic [31:0] live_f(int rxc, int txc, int rt, int tt);
    logic [31:0] v = '0;
    v[0] = rxc >= rt; v[1] = rxc == 0; v[2] = rxc == DEPTH;
    v[3] = txc == 0;  v[4] = txc == DEPTH; v[13] = txc >= tt;
    return v;
  endfunction

  function automatic logic [31:0] set_f(logic [31:0] lv, logic [5:0] e);
    logic [31:0] s = '0;
    s[4:0] = lv[4:0]; s[10] = lv[13];
    s[5] = e[0]; s[6] = e[1]; s[7] = e[2]; s[8] = e[3]; s[9] = e[4]; s[12] = e[5];
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] v);
    reg_idx = i; #0.3; v = reg_rdata;
  endtask

  // one clock with the given inputs; the model follows the requirements
  task automatic step(bit wr, logic [2:0] idx, logic [31:0] wd, int rxc, int txc, logic [5:0] e);
    logic [31:0] lv, nstk, nmask, clr;
    logic [5:0]  nrt, ntt;
    @(negedge clk);
    reg_wr = wr; reg_idx = idx; reg_wdata = wd;
    rx_count = 7'(rxc); tx_count = 7'(txc); ev = e;
    cur_rx = rxc; cur_tx = txc;
    lv    = live_f(rxc, txc, m_rt, m_tt);
    clr   = (wr && idx == 3'd3) ? wd : 32'h0;
    nstk  = ((m_stk & ~clr) | set_f(lv, e)) & 32'h17FF;
    nmask = m_mask;
    if (wr && idx == 3'd0) nmask = m_mask | (wd & 32'h17FF);
    if (wr && idx == 3'd1) nmask = m_mask & ~wd;
    nrt = (wr && idx == 3'd4) ? wd[5:0] : m_rt;
    ntt = (wr && idx == 3'd5) ? wd[5:0] : m_tt;
    @(posedge clk);
    m_stk = nstk; m_mask = nmask; m_rt = nrt; m_tt = ntt;
    #0.2; reg_wr = 1'b0; ev = '0;
  endtask

  task automatic check_all();
    logic [31:0] v;
    chk("R9 irq", {31'h0, irq}, {31'h0, |(m_mask & m_stk)});
    rd(3'd2, v); chk("R5 mask", v, m_mask);
    rd(3'd3, v); chk("R3/R4/R7 sticky", v, m_stk);
    rd(3'd6, v); chk("R1/R2 live", v, live_f(cur_rx, cur_tx, m_rt, m_tt));
    rd(3'd4, v); chk("R11 rx trigger", v, 32'(m_rt));
    rd(3'd5, v); chk("R11 tx trigger", v, 32'(m_tt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr = 1'b0; reg_idx = '0; reg_wdata = '0;
    rx_count = '0; tx_count = '0; ev = '0;
    m_mask = '0; m_stk = '0; m_rt = 6'd32; m_tt = 6'd32;
    cur_rx = 0; cur_tx = 0;
    #12;
    // R10 reset values
    chk("R10 irq in reset", {31'h0, irq}, 32'h0);
    rd(3'd2, v); chk("R10 mask in reset", v, 32'h0);
    rd(3'd3, v); chk("R10 sticky in reset", v, 32'h0);
    rd(3'd4, v); chk("R10 rx trigger in reset", v, 32'd32);
    rd(3'd5, v); chk("R10 tx trigger in reset", v, 32'd32);
    @(negedge clk); rst_n = 1'b1;

    // R3 empty bits latch
    step(0, 3'd0, 0, 0, 0, 6'h0); check_all();
    rd(3'd3, v); chk("R3 empty bits latched", v, 32'h0000_000A);
    // R5 enable all
    step(1, 3'd0, 32'hFFFF_FFFF, 0, 0, 6'h0); check_all();
    rd(3'd2, v); chk("R5 enable keeps implemented bits", v, 32'h0000_17FF);
    chk("R9 irq with mask and sticky", {31'h0, irq}, 32'h1);
    // R6 write to mask ignored
    step(1, 3'd2, 32'h0, 0, 0, 6'h0); check_all();
    rd(3'd2, v); chk("R6 mask write ignored", v, 32'h0000_17FF);
    // R5 disable
    step(1, 3'd1, 32'h0000_17F5, 0, 0, 6'h0); check_all();
    rd(3'd2, v); chk("R5 disable clears written bits", v, 32'h0000_000A);
    // R7 clear all with non-empty counts
    step(1, 3'd3, 32'hFFFF_FFFF, 5, 10, 6'h0); check_all();
    rd(3'd3, v); chk("R7 clear all", v, 32'h0);
    chk("R9 irq low after clear", {31'h0, irq}, 32'h0);
    // R8 event beats clear
    step(1, 3'd3, 32'h0000_0100, 5, 10, 6'h08); check_all();
    rd(3'd3, v); chk("R8 timeout survives clear", v, 32'h0000_0100);
    // R4 all events
    step(0, 3'd0, 0, 5, 10, 6'h3F); check_all();
    rd(3'd3, v); chk("R4 event bits", v, 32'h0000_13E0);
    // R1 full with trigger change
    step(1, 3'd4, 32'd40, 64, 64, 6'h0); check_all();
    rd(3'd6, v); chk("R1 full and trigger live bits", v, 32'h0000_2015);
    // R11 wide write truncated
    step(1, 3'd5, 32'hFFFF_FF3F, 62, 62, 6'h0); check_all();
    rd(3'd5, v); chk("R11 tx trigger 6 bits", v, 32'h0000_003F);
    rd(3'd6, v); chk("R2 below tx trigger", v, 32'h0000_0001);
    // R2 at tx trigger, bit 10 latched
    step(1, 3'd3, 32'hFFFF_FFFF, 0, 63, 6'h0); check_all();
    rd(3'd3, v); chk("R3 tx trigger at bit 10", v, 32'h0000_0402);

    // random mix with corner bias
    for (int n = 0; n < 3000; n++) begin
      int rxc, txc, k;
      logic [5:0] e;
      k = $urandom_range(0, 7);
      rxc = (k == 0) ? 0 : (k == 1) ? DEPTH : (k == 2) ? int'(m_rt) : $urandom_range(0, DEPTH);
      k = $urandom_range(0, 7);
      txc = (k == 0) ? 0 : (k == 1) ? DEPTH : (k == 2) ? int'(m_tt) : $urandom_range(0, DEPTH);
      e = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h0;
      step($urandom_range(0, 2) == 0, 3'($urandom), $urandom, rxc, txc, e);
      check_all();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule